// File: doc/BRIEF.md
# Byte-Masked Asynchronous SRAM Controller

This block sits between a synchronous host and an external asynchronous static RAM of 512K words by 16 bits. The host presents one request at a time: an address, write data, a two-bit byte enable and a read/write select, qualified by `req` and accepted in any cycle where `rdy` is high. The controller turns each request into active-low chip, output, write and per-byte strobes on the memory side. It drives a 19-bit address and a split data bus made of an output word, an input word and an output-enable.

All memory timing comes from counting clock cycles. Each count is a parameter derived from the clock period and the memory's access, pulse, setup and turnaround times, rounded up. A write lasts while chip select, write enable and a byte strobe are all low, and the controller ends it by raising the byte strobes. Write enable stays low through that closing cycle. A further write accepted in that cycle starts at once on the new address without write enable ever rising. Read data is sampled in the last access cycle and returned to the host with a one-cycle valid pulse.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held, and right after it is released, all five memory strobes are high, `mem_dq_oe` is low, `rdy` is high and `rd_valid` is low.
- R2: A write drives chip select and write enable low with output enable high. The lower byte strobe `mem_lb_n` (bits 7..0) is low when `req_be[0]` is set, and the upper strobe `mem_ub_n` (bits 15..8) is low when `req_be[1]` is set. Only the enabled lanes change in memory. With `req_be` = 2'b00, no lane is written.
- R3: Each write ends with the byte strobes rising while chip select and write enable are still low. Address and data do not change while a strobe is low.
- R4: A write request accepted in the closing cycle of a write keeps write enable low without a break. Three chained writes hold it low for 3 × (write count + 1) cycles.
- R5: A read drives chip select and output enable low with write enable high, and strobes only the enabled lanes. The data is sampled in the last access cycle. `rd_valid` is high for exactly one cycle, in the next cycle. Lanes that were not enabled read as zero.
- R6: `mem_dq_oe` is high only while write enable is low and output enable is high.
- R7: Between a write and a following read, or a read and a following write, there is at least the turnaround count of cycles in which neither the data bus nor the memory outputs are enabled.
- R8: `rdy` is low while a read access or a write strobe phase is in progress. It is high when idle and in the closing cycle of a write.
- R9: Whenever chip select is high, write enable, output enable and both byte strobes are also high, and `mem_dq_oe` is low.
- R10: A read access lasts ceil(T_AA_PS/CLK_PS) cycles. The write strobe phase lasts the larger of ceil(T_PWE_PS/CLK_PS) and ceil(T_SD_PS/CLK_PS) cycles. The turnaround lasts ceil(T_TA_PS/CLK_PS) cycles. Each count is at least one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request valid |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enable, bit 1 upper lane, bit 0 lower lane |
| rdy | output | 1 | Request accepted this cycle when high with `req` |
| rd_data | output | 16 | Read data, unenabled lanes zero |
| rd_valid | output | 1 | One-cycle read data strobe |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_addr | output | 19 | Memory address |
| mem_dq_o | output | 16 | Data driven to the memory |
| mem_dq_i | input | 16 | Data returned by the memory |
| mem_dq_oe | output | 1 | Data bus drive enable |

## Verification
The properties assume that the host holds `req_*` stable while `req` is high and `rdy` is low. They also assume the memory only returns data during a read cycle. The driver changes requests only at the falling edge, after it has seen `rdy` high. The memory model drives a filler byte on any lane it does not enable, and never on a lane it does enable. The model writes a lane only when that lane's write window closes, so a window closed the wrong way, or data that changes too late, shows up in the read-back values.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_READ,
        ST_WPULSE,
        ST_WCLOSE
    } seq_state_e;

    // memory pin pattern, all strobes active low except stb_on / dq_oe
    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic stb_on;
        logic dq_oe;
    } pin_set_t;

    localparam pin_set_t PINS_OFF    = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, stb_on: 1'b0, dq_oe: 1'b0};
    localparam pin_set_t PINS_READ   = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, stb_on: 1'b1, dq_oe: 1'b0};
    localparam pin_set_t PINS_WPULSE = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, stb_on: 1'b1, dq_oe: 1'b1};
    localparam pin_set_t PINS_WCLOSE = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, stb_on: 1'b0, dq_oe: 1'b1};

    // cycles needed to cover a time, never below one
    function automatic int cycles_for(input int t_ps, input int clk_ps);
        int c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_lane.sv
`timescale 1ns/1ps
module asram_lane #(
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          en_in,
    input  logic [LW-1:0] wd_in,
    input  logic          stb_on,
    input  logic          capture,
    input  logic [LW-1:0] dq_in,
    output logic          strb_n,
    output logic [LW-1:0] dq_out,
    output logic [LW-1:0] rd_out
);

    typedef struct packed {
        logic          en;
        logic [LW-1:0] wd;
        logic [LW-1:0] rd;
    } lane_t;

    lane_t q, d;

    always_comb begin
        d = q;
        if (load) begin
            d.en = en_in;
            d.wd = wd_in;
        end
        if (capture) begin
            d.rd = q.en ? dq_in : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign strb_n = ~(stb_on & q.en);
    assign dq_out = q.wd;
    assign rd_out = q.rd;

endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
    import asram_pkg::*;
#(
    parameter int AW     = 19,
    parameter int RD_CYC = 3,
    parameter int WR_CYC = 2,
    parameter int TA_CYC = 1,
    parameter int CW     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    output logic          rdy,
    output logic          accept,
    output logic          capture,
    output logic          rvalid,
    output pin_set_t      pins,
    output logic [AW-1:0] addr
);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
        logic          pend_wr;
        logic          last_rd;
        logic          last_wr;
        logic [AW-1:0] addr;
        pin_set_t      pins;
        logic          rvalid;
    } seq_t;

    localparam logic [CW-1:0] RD_LAST = CW'(RD_CYC - 1);
    localparam logic [CW-1:0] WR_LAST = CW'(WR_CYC - 1);
    localparam logic [CW-1:0] TA_LAST = CW'(TA_CYC - 1);

    seq_t q, d;
    logic need_turn;

    always_comb begin
        d         = q;
        d.rvalid  = 1'b0;
        capture   = 1'b0;
        rdy       = (q.st == ST_IDLE) || (q.st == ST_WCLOSE);
        accept    = req && rdy;
        need_turn = req_wr ? q.last_rd : q.last_wr;

        case (q.st)
            ST_IDLE, ST_WCLOSE: begin
                if (accept) begin
                    d.addr    = req_addr;
                    d.pend_wr = req_wr;
                    d.last_wr = req_wr;
                    d.last_rd = !req_wr;
                    if (need_turn) begin
                        d.st   = ST_TURN;
                        d.cnt  = TA_LAST;
                        d.pins = PINS_OFF;
                    end else if (req_wr) begin
                        d.st   = ST_WPULSE;
                        d.cnt  = WR_LAST;
                        d.pins = PINS_WPULSE;
                    end else begin
                        d.st   = ST_READ;
                        d.cnt  = RD_LAST;
                        d.pins = PINS_READ;
                    end
                end else begin
                    d.st   = ST_IDLE;
                    d.pins = PINS_OFF;
                end
            end
            ST_TURN: begin
                if (q.cnt == '0) begin
                    if (q.pend_wr) begin
                        d.st   = ST_WPULSE;
                        d.cnt  = WR_LAST;
                        d.pins = PINS_WPULSE;
                    end else begin
                        d.st   = ST_READ;
                        d.cnt  = RD_LAST;
                        d.pins = PINS_READ;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_READ: begin
                if (q.cnt == '0) begin
                    capture  = 1'b1;
                    d.rvalid = 1'b1;
                    d.st     = ST_IDLE;
                    d.pins   = PINS_OFF;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_WPULSE: begin
                if (q.cnt == '0) begin
                    d.st   = ST_WCLOSE;
                    d.pins = PINS_WCLOSE;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: begin
                d.st   = ST_IDLE;
                d.pins = PINS_OFF;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.pins <= PINS_OFF;
        end else begin
            q <= d;
        end
    end

    assign pins   = q.pins;
    assign addr   = q.addr;
    assign rvalid = q.rvalid;

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int AW       = 19,
    parameter int LW       = 8,
    parameter int CLK_PS   = 4000,
    parameter int T_AA_PS  = 10000,
    parameter int T_PWE_PS = 8000,
    parameter int T_SD_PS  = 6000,
    parameter int T_TA_PS  = 3000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               req_wr,
    input  logic [AW-1:0]      req_addr,
    input  logic [2*LW-1:0]    req_wdata,
    input  logic [1:0]         req_be,
    output logic               rdy,
    output logic [2*LW-1:0]    rd_data,
    output logic               rd_valid,
    output logic               mem_ce_n,
    output logic               mem_oe_n,
    output logic               mem_we_n,
    output logic               mem_ub_n,
    output logic               mem_lb_n,
    output logic [AW-1:0]      mem_addr,
    output logic [2*LW-1:0]    mem_dq_o,
    input  logic [2*LW-1:0]    mem_dq_i,
    output logic               mem_dq_oe
);

    localparam int NB     = 2;
    localparam int RD_CYC = cycles_for(T_AA_PS, CLK_PS);
    localparam int WR_CYC = max_of(cycles_for(T_PWE_PS, CLK_PS), cycles_for(T_SD_PS, CLK_PS));
    localparam int TA_CYC = cycles_for(T_TA_PS, CLK_PS);
    localparam int CW     = $clog2(max_of(max_of(RD_CYC, WR_CYC), TA_CYC) + 1);

    pin_set_t        pins;
    logic            accept;
    logic            capture;
    logic [NB-1:0]   strb_n;

    asram_seq #(
        .AW     (AW),
        .RD_CYC (RD_CYC),
        .WR_CYC (WR_CYC),
        .TA_CYC (TA_CYC),
        .CW     (CW)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_wr   (req_wr),
        .req_addr (req_addr),
        .rdy      (rdy),
        .accept   (accept),
        .capture  (capture),
        .rvalid   (rd_valid),
        .pins     (pins),
        .addr     (mem_addr)
    );

    for (genvar g = 0; g < NB; g++) begin : g_lane
        asram_lane #(.LW(LW)) lane_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (accept),
            .en_in   (req_be[g]),
            .wd_in   (req_wdata[g*LW +: LW]),
            .stb_on  (pins.stb_on),
            .capture (capture),
            .dq_in   (mem_dq_i[g*LW +: LW]),
            .strb_n  (strb_n[g]),
            .dq_out  (mem_dq_o[g*LW +: LW]),
            .rd_out  (rd_data[g*LW +: LW])
        );
    end

    assign mem_ce_n  = pins.ce_n;
    assign mem_oe_n  = pins.oe_n;
    assign mem_we_n  = pins.we_n;
    assign mem_dq_oe = pins.dq_oe;
    assign mem_lb_n  = strb_n[0];
    assign mem_ub_n  = strb_n[1];

endmodule

// File: rtl/asram_chk.sv
`timescale 1ns/1ps
module asram_chk #(
    parameter int AW = 19,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rdy,
    input logic          rd_valid,
    input logic          mem_ce_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic          mem_ub_n,
    input logic          mem_lb_n,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_dq_o,
    input logic          mem_dq_oe
);

    a_r9_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n && !mem_dq_oe));

    a_r6_drive_in_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && mem_oe_n));

    a_r2_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    a_r7_gap_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mem_dq_oe) |-> mem_oe_n);

    a_r7_gap_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!mem_oe_n) |-> (mem_we_n && !mem_dq_oe));

    a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || (!mem_we_n && !(mem_ub_n && mem_lb_n))) |-> !rdy);

    a_r3_window_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && !mem_ce_n && $past(!mem_we_n && !mem_ce_n && !(mem_ub_n && mem_lb_n)))
        |-> ($stable(mem_dq_o) && $stable(mem_addr)));

endmodule

bind asram_ctrl asram_chk #(.AW(AW), .DW(2*LW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rdy       (rdy),
    .rd_valid  (rd_valid),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_ub_n  (mem_ub_n),
    .mem_lb_n  (mem_lb_n),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/asram_ctrl_tb_top.sv
`timescale 1ns/1ps
module asram_ctrl_tb_top;

    localparam int P_CLK = 4000;
    localparam int EXP_RD = (10000 + P_CLK - 1) / P_CLK;
    localparam int EXP_WR = ((8000 > 6000 ? 8000 : 6000) + P_CLK - 1) / P_CLK;
    localparam int EXP_TA = (3000 + P_CLK - 1) / P_CLK;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_wr = 1'b0;
    logic [18:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        rdy;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;
    logic [18:0] mem_addr;
    logic [15:0] mem_dq_o;
    logic [15:0] mem_dq_i = 16'hA5A5;
    logic        mem_dq_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [15:0] store [int];
    logic [15:0] shadow [int];
    logic [15:0] expq [$];

    asram_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .rdy(rdy), .rd_data(rd_data),
        .rd_valid(rd_valid), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
        .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i),
        .mem_dq_oe(mem_dq_oe)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // ---------------- memory model and monitors (sampled mid-cycle) ----------------
    logic        ce_p = 1'b1, oe_p = 1'b1, we_p = 1'b1;
    logic [1:0]  win_p = 2'b00;
    logic [1:0]  win_n;
    logic [18:0] addr_p = '0;
    logic [15:0] dq_p = '0;
    logic [15:0] word, got;
    int          wrun = 0, rrun = 0, werun = 0, last_werun = 0, gap = 0;
    bit          have_last = 1'b0, last_is_wr = 1'b0;
    bit          rd_on;

    always @(negedge clk) begin
        if (rst_n) begin
            win_n[0] = !mem_ce_n && !mem_we_n && !mem_lb_n;
            win_n[1] = !mem_ce_n && !mem_we_n && !mem_ub_n;
            // commit a lane when its write window closes
            for (int l = 0; l < 2; l++) begin
                if (win_p[l] && (!win_n[l] || mem_addr != addr_p)) begin
                    word = store.exists(int'(addr_p)) ? store[int'(addr_p)] : 16'h0000;
                    word[l*8 +: 8] = dq_p[l*8 +: 8];
                    store[int'(addr_p)] = word;
                end
            end
            if (|win_n) begin
                wrun++;
            end else if (|win_p) begin
                chk(wrun == EXP_WR, "R10 write strobe length", wrun, EXP_WR);
                chk(!mem_we_n && !mem_ce_n, "R3 window closed by byte strobe", {mem_we_n, mem_ce_n}, 0);
                wrun = 0;
            end
            // read access window
            if (!mem_oe_n) begin
                rrun++;
                if (oe_p) begin
                    chk(!rdy, "R8 ready low in read", rdy, 0);
                    if (have_last && last_is_wr) chk(gap >= EXP_TA, "R7 write to read gap", gap, EXP_TA);
                end
            end else if (!oe_p) begin
                chk(rrun == EXP_RD, "R10 read access length", rrun, EXP_RD);
                rrun = 0;
            end
            // write enable run
            if (!mem_we_n) begin
                werun++;
                if (we_p) begin
                    chk(mem_dq_oe && mem_oe_n, "R6 bus driven with OE high in write", {mem_dq_oe, mem_oe_n}, 2'b11);
                    if (have_last && !last_is_wr) chk(gap >= EXP_TA, "R7 read to write gap", gap, EXP_TA);
                end
            end else if (!we_p) begin
                last_werun = werun;
                werun = 0;
            end
            if (mem_ce_n && !ce_p)
                chk(mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n && !mem_dq_oe, "R9 deselected quiet",
                    {mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe}, 5'b11110);
            if (mem_dq_oe) begin
                gap = 0; last_is_wr = 1'b1; have_last = 1'b1;
            end else if (!mem_oe_n) begin
                gap = 0; last_is_wr = 1'b0; have_last = 1'b1;
            end else begin
                gap++;
            end
            // read return check
            if (rd_valid) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R5 unexpected valid", rd_data, 0);
                end else begin
                    got = expq.pop_front();
                    chk(rd_data == got, "R5 read data", rd_data, got);
                end
            end
            // memory drives enabled lanes during a read
            rd_on = !mem_ce_n && !mem_oe_n && mem_we_n;
            word = store.exists(int'(mem_addr)) ? store[int'(mem_addr)] : 16'h0000;
            mem_dq_i = {(rd_on && !mem_ub_n) ? word[15:8] : 8'hA5,
                        (rd_on && !mem_lb_n) ? word[7:0]  : 8'hA5};
            win_p  = win_n;
            addr_p = mem_addr;
            dq_p   = mem_dq_o;
            ce_p   = mem_ce_n;
            oe_p   = mem_oe_n;
            we_p   = mem_we_n;
        end
    end

    // ---------------- driver ----------------
    task automatic issue(input bit wr, input logic [18:0] a, input logic [15:0] dat, input logic [1:0] be);
        logic [15:0] s;
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = dat; req_be = be;
        while (!rdy) @(negedge clk);
        @(negedge clk);
        req = 1'b0;
        s = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
        if (wr) begin
            if (be[0]) s[7:0]  = dat[7:0];
            if (be[1]) s[15:8] = dat[15:8];
            shadow[int'(a)] = s;
        end else begin
            expq.push_back({be[1] ? s[15:8] : 8'h00, be[0] ? s[7:0] : 8'h00});
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n && !mem_dq_oe && !rd_valid,
            "R1 pins in reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe, rd_valid}, 7'b1111100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rdy && mem_ce_n && !mem_dq_oe && !rd_valid, "R1 after reset", {rdy, mem_ce_n, mem_dq_oe, rd_valid}, 4'b1100);

        // R2 full word write, R5 read back
        issue(1'b1, 19'h00010, 16'h1234, 2'b11);
        repeat (4) @(negedge clk);
        chk(last_werun == EXP_WR + 1, "R3 single write WE span", last_werun, EXP_WR + 1);
        issue(1'b0, 19'h00010, 16'h0000, 2'b11);
        // R2 upper-lane-only write
        issue(1'b1, 19'h00010, 16'hABCD, 2'b10);
        issue(1'b0, 19'h00010, 16'h0000, 2'b11);
        // R5 lane-masked reads
        issue(1'b0, 19'h00010, 16'h0000, 2'b01);
        issue(1'b0, 19'h00010, 16'h0000, 2'b10);
        // R2 write with no lanes enabled leaves memory unchanged
        issue(1'b1, 19'h00010, 16'hFFFF, 2'b00);
        issue(1'b0, 19'h00010, 16'h0000, 2'b11);
        // R4 chained writes at address extremes
        issue(1'b1, 19'h7FFFF, 16'hBEEF, 2'b11);
        issue(1'b1, 19'h00000, 16'h5A5A, 2'b01);
        issue(1'b1, 19'h40000, 16'hC3C3, 2'b10);
        repeat (4) @(negedge clk);
        chk(last_werun == 3 * (EXP_WR + 1), "R4 WE held low across chained writes", last_werun, 3 * (EXP_WR + 1));
        issue(1'b0, 19'h7FFFF, 16'h0000, 2'b11);
        issue(1'b0, 19'h00000, 16'h0000, 2'b11);
        issue(1'b0, 19'h40000, 16'h0000, 2'b11);
        issue(1'b0, 19'h12345, 16'h0000, 2'b11);
        // lower-lane write then merged read
        issue(1'b1, 19'h40000, 16'h003C, 2'b01);
        issue(1'b0, 19'h40000, 16'h0000, 2'b11);
        repeat (20) @(negedge clk);
        chk(expq.size() == 0, "R5 all reads returned", expq.size(), 0);
        chk(rdy && mem_ce_n, "R8 ready when idle", {rdy, mem_ce_n}, 2'b11);
        finish_run();
    end

endmodule